// File: doc/BRIEF.md
# I2C Target with Software Clock Stretching

This block is the target (slave) side of an I2C bus. It watches the open-drain SCL and SDA lines through sense inputs and pulls them low through drive-enable outputs. It matches its own 7-bit or 10-bit address and acknowledges it. It can also answer the all-zero general call, or acknowledge every address it sees. After a match it receives bytes into a receive register or sends bytes from a transmit register, most significant bit first.

Software paces the transfer through one clock-release bit in the control register. While the bit is 0, the target holds SCL low as soon as the controller has pulled it low. Hardware clears the bit at fixed byte boundaries, and the stretch-enable bit decides which boundaries those are. After each boundary the controller waits until software has read or loaded the byte and written the bit back to 1. A one-cycle interrupt pulse marks each event that needs software attention.

Software reaches the registers through a single select field. Writes go to the control register (select 0), the own address (select 1) or the transmit byte (select 2). Reads return the control register (0), the own address (1), the received byte (2) or the status (3).

Top module: `i2c_target_stretch`

## Requirements
- R1: With the enable bit (control bit 0) at 0, the block drives neither line. A complete addressed write to its own address then gets no acknowledge and no interrupt, and the release bit keeps its value.
- R2: The release bit (control bit 6) reads 1 after reset. Writing 0 makes the block hold SCL low only once SCL has been observed low, and never while SCL is high. Writing 1 frees SCL.
- R3: While stretch-enable (control bit 1) is 0 before the write, a write of 0 to the release bit is ignored, and software can only set the bit.
- R4: In 7-bit mode (control bit 2 = 0), an address byte whose upper seven bits equal own address bits 6:0 is acknowledged. It raises one interrupt pulse, records its lowest bit (1 = read) in status bit 0, and clears the release bit after the acknowledge clock, so SCL is held.
- R5: In a read, the target shifts out the transmit byte MSB first and changes SDA only while SCL is low. The release bit is cleared at the start of every transmitted byte, meaning after the address acknowledge and after every controller ACK. After a controller NACK the target lets go of both lines and waits.
- R6: After a received data byte, the byte is readable at select 2. The release bit is cleared, and SCL held, only when stretch-enable is 1. With stretch-enable at 0, SCL stays free.
- R7: The acknowledge for a received data byte is ACK when the NACK bit (control bit 5) is 0 and NACK when it is 1.
- R8: In 10-bit mode, a header byte 11110 a9 a8 0 matching own bits 9:8 is acknowledged without stretching. The low byte that follows must equal own bits 7:0 to be acknowledged and to complete the match. After a repeated START, the header with read bit is acknowledged only if that match was completed.
- R9: With accept-all (control bit 3) set, any address byte is acknowledged regardless of the own address.
- R10: With general-call enable (control bit 4) set, the address byte 0x00 is acknowledged, raises an interrupt and sets status bit 1. With general-call enable clear, 0x00 is not acknowledged.
- R11: An address byte that does not match gets no acknowledge, no stretch and no interrupt.
- R12: A repeated START restarts address matching. A STOP returns the block to idle and forgets a completed 10-bit match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for write and read |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data for the current select |
| irq | output | 1 | One-cycle pulse at address match, received byte, or transmit byte start |

## Verification
The hardest situation to reach is the 10-bit read. It needs a header with write direction and a matching low byte, both acknowledged. A release write must follow. Then comes a repeated START and a header with the read bit, which is accepted only because of the match made earlier. The bench reaches it with a bit-level controller model on a wired-AND bus that waits for SCL to actually rise. The bench releases the clock through register writes between bytes. It then repeats the read header after a STOP to show that the pairing is gone.

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [9:0] reg_wdata,
  output logic [9:0] reg_rdata,
  output logic       irq
);
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_OWN = 2'd1, SEL_DATA = 2'd2, SEL_STAT = 2'd3;
  localparam int ENB = 0, STRB = 1, TENB = 2, ALLB = 3, GCB = 4, NAKB = 5, RELB = 6;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR2, S_ACK, S_RX, S_TX, S_TXACK, S_WAIT} st_t;

  logic [2:0] scl_p, sda_p;
  logic scl_s, scl_q, sda_s, sda_q;
  logic scl_r, scl_f, start, stop;

  logic en, str_en, ten, all, gce, nack, rel;
  logic [9:0] own;
  logic [7:0] sh, txs, rxd;
  logic [3:0] cnt;
  st_t st, nxt;
  logic ackd, clr, mack, rw, gc_hit, ten_ok, hold;

  logic dec_ack, dec_fin, dec_rw, dec_gc;
  st_t dec_to;

  assign scl_s = scl_p[1];
  assign scl_q = scl_p[2];
  assign sda_s = sda_p[1];
  assign sda_q = sda_p[2];
  assign scl_r = scl_s & ~scl_q;
  assign scl_f = ~scl_s & scl_q;
  assign start = scl_s & scl_q & sda_q & ~sda_s;
  assign stop  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_comb begin
    dec_ack = 1'b0;
    dec_fin = 1'b0;
    dec_rw  = 1'b0;
    dec_gc  = 1'b0;
    dec_to  = S_WAIT;
    if (st == S_ADDR2) begin
      if (all || sh == own[7:0]) begin
        dec_ack = 1'b1;
        dec_fin = 1'b1;
        dec_to  = S_RX;
      end
    end else if (gce && sh == 8'h00) begin
      dec_ack = 1'b1;
      dec_fin = 1'b1;
      dec_gc  = 1'b1;
      dec_to  = S_RX;
    end else if (ten && sh[7:3] == 5'b11110) begin
      if (all || sh[2:1] == own[9:8]) begin
        if (!sh[0]) begin
          dec_ack = 1'b1;
          dec_to  = S_ADDR2;
        end else if (all || ten_ok) begin
          dec_ack = 1'b1;
          dec_fin = 1'b1;
          dec_rw  = 1'b1;
          dec_to  = S_TX;
        end
      end
    end else if (all || (!ten && sh[7:1] == own[6:0])) begin
      dec_ack = 1'b1;
      dec_fin = 1'b1;
      dec_rw  = sh[0];
      dec_to  = sh[0] ? S_TX : S_RX;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, str_en, ten, all, gce, nack} <= '0;
      rel    <= 1'b1;
      own    <= '0;
      sh     <= '0;
      txs    <= 8'hff;
      rxd    <= '0;
      cnt    <= '0;
      st     <= S_IDLE;
      nxt    <= S_IDLE;
      ackd   <= 1'b0;
      clr    <= 1'b0;
      mack   <= 1'b0;
      rw     <= 1'b0;
      gc_hit <= 1'b0;
      ten_ok <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (reg_we)
        case (reg_sel)
          SEL_CTRL: begin
            en     <= reg_wdata[ENB];
            str_en <= reg_wdata[STRB];
            ten    <= reg_wdata[TENB];
            all    <= reg_wdata[ALLB];
            gce    <= reg_wdata[GCB];
            nack   <= reg_wdata[NAKB];
            rel    <= str_en ? reg_wdata[RELB] : (rel | reg_wdata[RELB]);
          end
          SEL_OWN:  own <= reg_wdata;
          SEL_DATA: txs <= reg_wdata[7:0];
          default: ;
        endcase
      if (!en) begin
        st     <= S_IDLE;
        ten_ok <= 1'b0;
      end else if (start) begin
        st     <= S_ADDR;
        cnt    <= '0;
        gc_hit <= 1'b0;
      end else if (stop) begin
        st     <= S_IDLE;
        ten_ok <= 1'b0;
      end else
        case (st)
          S_ADDR, S_ADDR2, S_RX:
            if (scl_r) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_f && cnt == 4'd8) begin
              if (st == S_RX) begin
                rxd  <= sh;
                irq  <= 1'b1;
                ackd <= ~nack;
                clr  <= str_en;
                nxt  <= S_RX;
                st   <= S_ACK;
              end else if (dec_ack) begin
                ackd <= 1'b1;
                clr  <= dec_fin;
                irq  <= dec_fin;
                nxt  <= dec_to;
                st   <= S_ACK;
                if (dec_fin) rw <= dec_rw;
                if (dec_gc) gc_hit <= 1'b1;
                if (st == S_ADDR2) ten_ok <= 1'b1;
              end else begin
                st <= S_WAIT;
                if (st == S_ADDR2) ten_ok <= 1'b0;
              end
            end
          S_ACK:
            if (scl_f) begin
              st  <= nxt;
              cnt <= '0;
              if (clr) rel <= 1'b0;
            end
          S_TX:
            if (scl_r) cnt <= cnt + 4'd1;
            else if (scl_f) begin
              if (cnt == 4'd8) st <= S_TXACK;
              else txs <= {txs[6:0], 1'b1};
            end
          S_TXACK:
            if (scl_r) mack <= ~sda_s;
            else if (scl_f) begin
              if (mack) begin
                st  <= S_TX;
                cnt <= '0;
                rel <= 1'b0;
                irq <= 1'b1;
              end else st <= S_WAIT;
            end
          default: ;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold <= 1'b0;
    else if (!en || rel) hold <= 1'b0;
    else if (!scl_s) hold <= 1'b1;

  assign scl_oe = en & hold;
  assign sda_oe = en & (((st == S_ACK) & ackd) | ((st == S_TX) & ~txs[7]));

  always_comb
    case (reg_sel)
      SEL_CTRL: reg_rdata = {3'b000, rel, nack, gce, all, ten, str_en, en};
      SEL_OWN:  reg_rdata = own;
      SEL_DATA: reg_rdata = {2'b00, rxd};
      default:  reg_rdata = {7'b0, hold, gc_hit, rw};
    endcase

  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st == S_IDLE);
  p_hold_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !$past(scl_s));
  p_release_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rel) |-> !scl_oe);
  p_sda_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
  p_irq_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: tb/sim_i2c_target_stretch.sv
module sim_i2c_target_stretch;
  localparam int H = 20;
  localparam logic [9:0] EN = 10'h001, STR = 10'h002, TEN = 10'h004, ALL = 10'h008,
                         GCE = 10'h010, NAK = 10'h020, REL = 10'h040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic bus_scl, bus_sda;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] reg_rdata;
  int n_run = 0, n_fail = 0, irqs = 0;

  assign bus_scl = m_scl & ~scl_oe;
  assign bus_sda = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_target_stretch u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always @(negedge clk) if (irq) irqs <= irqs + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [9:0] v);
    reg_sel = s; reg_wdata = v; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
    tick(1);
  endtask

  task automatic rd(input logic [1:0] s, output logic [9:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
    tick(1);
  endtask

  task automatic wait_high();
    tick(1);
    while (!bus_scl) tick(1);
  endtask

  task automatic m_start();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic m_rstart();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; wait_high(); tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; wait_high(); tick(H);
    m_sda = 1'b1; tick(2 * H);
  endtask

  task automatic m_bit(input logic b, output logic r);
    m_sda = b; tick(H);
    m_scl = 1'b1; wait_high(); tick(H / 2);
    r = bus_sda; tick(H / 2);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(input logic nk, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r);
      d[i] = r;
    end
    m_bit(nk, r);
  endtask

  task automatic t_reset();
    logic [9:0] d;
    chk("R2 scl_oe after reset", scl_oe, 0);
    chk("R2 sda_oe after reset", sda_oe, 0);
    rd(0, d);
    chk("R2 ctrl after reset", d, REL);
  endtask

  task automatic t_disabled();
    logic ack; logic [9:0] d; int i0;
    wr(1, 10'h02A); wr(0, REL);
    i0 = irqs;
    m_start(); m_wbyte(8'h54, ack);
    chk("R1 no ack when off", ack, 0);
    chk("R1 no scl drive when off", scl_oe, 0);
    m_stop();
    chk("R1 no irq when off", irqs - i0, 0);
    rd(0, d);
    chk("R1 release untouched", d, REL);
  endtask

  task automatic t_sw_stretch();
    logic [9:0] d;
    wr(0, EN | STR | REL); wr(0, EN | STR);
    tick(5);
    chk("R2 no hold while scl high", scl_oe, 0);
    m_scl = 1'b0; tick(6);
    chk("R2 hold after scl low", scl_oe, 1);
    wr(0, EN | STR | REL); tick(2);
    chk("R2 release frees scl", scl_oe, 0);
    m_scl = 1'b1; tick(H);
    wr(0, EN | REL); wr(0, EN);
    rd(0, d);
    chk("R3 clear ignored without stretch-enable", d, EN | REL);
    m_scl = 1'b0; tick(6);
    chk("R3 no hold", scl_oe, 0);
    m_scl = 1'b1; tick(H);
  endtask

  task automatic t_write7();
    logic ack; logic [9:0] d; int i0;
    wr(1, 10'h02A); wr(0, EN | STR | REL);
    i0 = irqs;
    m_start(); m_wbyte(8'h54, ack);
    chk("R4 address ack", ack, 1);
    chk("R4 held after address", scl_oe, 1);
    chk("R4 one irq", irqs - i0, 1);
    rd(3, d); chk("R4 direction write", d[0], 0);
    rd(0, d); chk("R4 release cleared", d[6], 0);
    wr(0, EN | STR | REL);
    m_wbyte(8'hA5, ack);
    chk("R7 data ack", ack, 1);
    chk("R6 held after data", scl_oe, 1);
    rd(2, d); chk("R6 rx byte", d, 10'h0A5);
    wr(0, EN | STR | NAK | REL);
    m_wbyte(8'h3C, ack);
    chk("R7 data nack", ack, 0);
    wr(0, EN | STR | REL);
    m_stop();
  endtask

  task automatic t_nostretch();
    logic ack; logic [9:0] d;
    wr(0, EN | REL);
    m_start(); m_wbyte(8'h54, ack);
    chk("R4 held after address, no stretch-enable", scl_oe, 1);
    wr(0, EN | REL);
    m_wbyte(8'h11, ack);
    chk("R6 ack", ack, 1);
    chk("R6 no hold after data", scl_oe, 0);
    rd(2, d); chk("R6 rx byte", d, 10'h011);
    m_stop();
  endtask

  task automatic t_read();
    logic ack; logic [9:0] d; logic [7:0] b;
    wr(0, EN | STR | REL);
    m_start(); m_wbyte(8'h55, ack);
    chk("R4 read address ack", ack, 1);
    chk("R5 held before first byte", scl_oe, 1);
    rd(3, d); chk("R4 direction read", d[0], 1);
    wr(2, 10'h0C3); wr(0, EN | STR | REL);
    m_rbyte(1'b0, b);
    chk("R5 first byte", b, 8'hC3);
    chk("R5 held before second byte", scl_oe, 1);
    wr(2, 10'h05A); wr(0, EN | STR | REL);
    m_rbyte(1'b1, b);
    chk("R5 second byte", b, 8'h5A);
    chk("R5 scl free after nack", scl_oe, 0);
    chk("R5 sda free after nack", sda_oe, 0);
    m_stop();
  endtask

  task automatic t_mismatch();
    logic ack; int i0;
    wr(0, EN | STR | REL);
    i0 = irqs;
    m_start(); m_wbyte(8'h56, ack);
    chk("R11 no ack", ack, 0);
    chk("R11 no hold", scl_oe, 0);
    chk("R11 no irq", irqs - i0, 0);
    m_stop();
  endtask

  task automatic t_ten();
    logic ack; logic [9:0] d; logic [7:0] b; int i0;
    wr(1, 10'h2A5); wr(0, EN | STR | TEN | REL);
    i0 = irqs;
    m_start(); m_wbyte(8'hF4, ack);
    chk("R8 header ack", ack, 1);
    chk("R8 no hold after header", scl_oe, 0);
    m_wbyte(8'hA5, ack);
    chk("R8 low byte ack", ack, 1);
    chk("R8 held after match", scl_oe, 1);
    chk("R8 one irq", irqs - i0, 1);
    wr(0, EN | STR | TEN | REL);
    m_wbyte(8'h77, ack);
    rd(2, d); chk("R8 rx byte", d, 10'h077);
    wr(0, EN | STR | TEN | REL);
    m_rstart(); m_wbyte(8'hF5, ack);
    chk("R12 read header after repeated start", ack, 1);
    rd(3, d); chk("R8 direction read", d[0], 1);
    wr(2, 10'h081); wr(0, EN | STR | TEN | REL);
    m_rbyte(1'b1, b);
    chk("R8 read byte", b, 8'h81);
    m_stop();
    m_start(); m_wbyte(8'hF5, ack);
    chk("R12 read header refused after stop", ack, 0);
    m_stop();
    m_start(); m_wbyte(8'hF4, ack); m_wbyte(8'hA6, ack);
    chk("R8 wrong low byte", ack, 0);
    m_stop();
  endtask

  task automatic t_all();
    logic ack;
    wr(1, 10'h02A); wr(0, EN | STR | ALL | REL);
    m_start(); m_wbyte(8'h9E, ack);
    chk("R9 any address ack", ack, 1);
    chk("R9 held", scl_oe, 1);
    wr(0, EN | STR | REL);
    m_stop();
  endtask

  task automatic t_gc();
    logic ack; logic [9:0] d; int i0;
    wr(0, EN | STR | REL);
    m_start(); m_wbyte(8'h00, ack);
    chk("R10 general call ignored", ack, 0);
    m_stop();
    wr(0, EN | STR | GCE | REL);
    i0 = irqs;
    m_start(); m_wbyte(8'h00, ack);
    chk("R10 general call ack", ack, 1);
    chk("R10 irq", irqs - i0, 1);
    rd(3, d); chk("R10 status flag", d[1], 1);
    wr(0, EN | STR | GCE | REL);
    m_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_disabled();
    t_sw_stretch();
    t_write7();
    t_nostretch();
    t_read();
    t_mismatch();
    t_ten();
    t_all();
    t_gc();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule